// File: doc/BRIEF.md
# Infrared Run-Length Capture Receiver

This block watches the one-bit output of an infrared demodulator and records the received waveform as a stream of run-length bytes. The line is resynchronised to the core clock, optionally inverted, and sampled once every `SAMPLE_DIV` core clocks. A glitch filter then removes level changes that are too short to be real. The filtered level is turned into bytes. Each byte carries the level of one run and the number of sample ticks the run lasted. The bytes go into a receive FIFO.

A packet begins at the first high sample after an idle period. It ends when the line has stayed low for a programmable number of ticks. The low run that ends the packet is not stored, so software sees only the marks and the gaps inside the packet. Software reads a status word. It holds the FIFO fill count and three sticky event flags: fill level reached, packet end and overflow. The flags are cleared by writing ones to them. Software drains the FIFO one byte at a time through a pop strobe.

Top module: `ir_rle_rx`

## Requirements
- R1: Each stored byte holds the run level in bit 7 (1 = high, 0 = low) and the run length in sample ticks in bits 6:0. One tick occurs every `SAMPLE_DIV` clocks. A run of N ticks, with 1 <= N <= 127, produces one byte with length N.
- R2: A run longer than 127 ticks is split. On the 128th tick a byte with length 127 is stored, and counting restarts at 1 with the same level. A run of exactly 127 ticks produces a single byte.
- R3: Low samples before the first high sample are ignored. The packet ends once the low level has lasted `idle_thr` ticks. At that point status bit 1 (packet end) is set, and the low run in progress is discarded. A low run shorter than `idle_thr` is stored normally.
- R4: The filtered level follows a new input level only after that level has been present for `glitch_thr` consecutive ticks. A shorter excursion adds to the surrounding run and is not stored as a byte.
- R5: When `inv` is 1, the synchronised input is inverted before sampling, so a low pulse on `ir_in` is stored with level 1.
- R6: While `en` is 0, no bytes are stored, the capture state is cleared and no flag is raised by the capture path.
- R7: The FIFO holds `DEPTH` (64) bytes in arrival order. Status bits 14:8 give the fill count. A pop returns the oldest byte on `pop_data` with `pop_vld` high in the next cycle. A pop on an empty FIFO leaves `pop_vld` low.
- R8: A byte that arrives while the FIFO is full is dropped, the fill count does not change, and status bit 2 (overflow) is set.
- R9: Status bit 0 (fill level) is set on every cycle where `lvl_trig` is non-zero and the fill count is at least `lvl_trig`.
- R10: When `clr_we` is high, each status flag whose `clr_bits` bit is 1 is cleared, and the other flags keep their values. `irq` is high whenever any flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Capture enable |
| inv | input | 1 | Invert the input line before sampling |
| glitch_thr | input | 7 | Minimum ticks for an accepted level change |
| idle_thr | input | IDLE_W | Low ticks that end a packet |
| lvl_trig | input | 7 | Fill level that raises the level flag; 0 disables it |
| ir_in | input | 1 | Demodulated infrared line, asynchronous |
| clr_we | input | 1 | Flag clear strobe |
| clr_bits | input | 3 | Flags to clear: bit 0 level, bit 1 packet end, bit 2 overflow |
| stat | output | 16 | Status word: fill count in 14:8, flags in 2:0 |
| irq | output | 1 | Any flag set |
| pop | input | 1 | Read one byte from the FIFO |
| pop_data | output | 8 | Byte read by the previous pop |
| pop_vld | output | 1 | `pop_data` holds a fresh byte |

## Verification
The embedded assertions check rules that hold in every cycle:
- sample ticks never occur on two consecutive clocks;
- the filtered level changes only on a tick;
- no stored byte has a zero length;
- nothing is pushed while the block is disabled;
- the fill count never exceeds the depth;
- a push into a full FIFO leaves the count unchanged;
- the overflow flag rises only after a cycle with a full FIFO;
- a written clear takes effect.

The values of the runs need the bench's scenarios. These cover exact lengths, the split at 127, the discarded trailing idle run, glitch merging, inversion and FIFO order after an overflow.

// File: rtl/ir_rle_pkg.sv
package ir_rle_pkg;
  localparam int RUN_W = 7;
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  localparam int FLG_N   = 3;
  localparam int FLG_LVL = 0;
  localparam int FLG_END = 1;
  localparam int FLG_OVF = 2;

  typedef struct packed {
    logic             lvl;
    logic [RUN_W-1:0] len;
  } run_byte_t;
endpackage

// File: rtl/ir_tick_div.sv
module ir_tick_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + CW'(1);
      tick <= 1'b0;
    end
  end

  generate
    if (DIV > 1) begin : g_gap
      // R1
      tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/ir_glitch_filt.sv
module ir_glitch_filt
  import ir_rle_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic             din,
  input  logic [RUN_W-1:0] thr,
  output logic             filt
);
  logic             samp;
  logic [RUN_W-1:0] dcnt;
  logic [RUN_W:0]   dnext;

  assign dnext = {1'b0, dcnt} + (RUN_W+1)'(1);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      samp <= 1'b0;
      filt <= 1'b0;
      dcnt <= '0;
    end else if (tick) begin
      samp <= din;
      if (samp != filt) begin
        if (dnext >= {1'b0, thr}) begin
          filt <= samp;
          dcnt <= '0;
        end else begin
          dcnt <= dnext[RUN_W-1:0];
        end
      end else begin
        dcnt <= '0;
      end
    end
  end

  // R4
  filt_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> $stable(filt));
endmodule

// File: rtl/ir_run_enc.sv
module ir_run_enc
  import ir_rle_pkg::*;
#(
  parameter int IDLE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  input  logic              lvl_in,
  input  logic [IDLE_W-1:0] idle_thr,
  output logic              push,
  output run_byte_t         dout,
  output logic              pkt_end
);
  logic              active, act_n;
  logic              cur, cur_n;
  logic [RUN_W-1:0]  cnt, cnt_n;
  logic [IDLE_W-1:0] idle_cnt, idle_n;
  logic [IDLE_W:0]   idle_inc;
  logic              idle_hit;
  logic              push_n, end_n;
  run_byte_t         dout_n;

  assign idle_inc = {1'b0, idle_cnt} + (IDLE_W+1)'(1);
  assign idle_hit = (idle_inc >= {1'b0, idle_thr});

  always_comb begin
    act_n  = active;
    cur_n  = cur;
    cnt_n  = cnt;
    idle_n = idle_cnt;
    push_n = 1'b0;
    end_n  = 1'b0;
    dout_n = dout;
    if (tick) begin
      if (!active) begin
        if (lvl_in) begin
          act_n  = 1'b1;
          cur_n  = 1'b1;
          cnt_n  = RUN_W'(1);
          idle_n = '0;
        end
      end else if (lvl_in != cur) begin
        push_n     = 1'b1;
        dout_n.lvl = cur;
        dout_n.len = cnt;
        cur_n      = lvl_in;
        cnt_n      = RUN_W'(1);
        if (lvl_in) begin
          idle_n = '0;
        end else begin
          idle_n = IDLE_W'(1);
          if (idle_thr <= IDLE_W'(1)) begin
            act_n  = 1'b0;
            end_n  = 1'b1;
            cnt_n  = '0;
            idle_n = '0;
          end
        end
      end else if (!lvl_in && idle_hit) begin
        act_n  = 1'b0;
        end_n  = 1'b1;
        cnt_n  = '0;
        idle_n = '0;
      end else begin
        if (!lvl_in) idle_n = idle_inc[IDLE_W-1:0];
        if (cnt == RUN_MAX) begin
          push_n     = 1'b1;
          dout_n.lvl = cur;
          dout_n.len = RUN_MAX;
          cnt_n      = RUN_W'(1);
        end else begin
          cnt_n = cnt + RUN_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      active   <= 1'b0;
      cur      <= 1'b0;
      cnt      <= '0;
      idle_cnt <= '0;
      push     <= 1'b0;
      pkt_end  <= 1'b0;
      dout     <= '0;
    end else begin
      active   <= act_n;
      cur      <= cur_n;
      cnt      <= cnt_n;
      idle_cnt <= idle_n;
      push     <= push_n;
      pkt_end  <= end_n;
      dout     <= dout_n;
    end
  end

  // R1
  len_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> (dout.len != '0));
  // R6
  en_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!push && !pkt_end));
endmodule

// File: rtl/ir_byte_fifo.sv
module ir_byte_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          dvld,
  output logic [CW-1:0] count,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_wr, do_rd;

  assign full  = (count == CW'(DEPTH));
  assign do_wr = push && !full;
  assign do_rd = pop && (count != '0);

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (do_rd) dout <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      dvld   <= 1'b0;
    end else begin
      dvld <= do_rd;
      if (do_wr) wr_ptr <= wr_ptr + AW'(1);
      if (do_rd) rd_ptr <= rd_ptr + AW'(1);
      case ({do_wr, do_rd})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R7
  fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  // R8
  drop_full_chk: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> $stable(count));
  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && count == '0) |=> !dvld);
endmodule

// File: rtl/ir_rle_rx.sv
module ir_rle_rx
  import ir_rle_pkg::*;
#(
  parameter int SAMPLE_DIV = 4,
  parameter int DEPTH      = 64,
  parameter int IDLE_W     = 12,
  parameter int SYNC_N     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              inv,
  input  logic [6:0]        glitch_thr,
  input  logic [IDLE_W-1:0] idle_thr,
  input  logic [6:0]        lvl_trig,
  input  logic              ir_in,
  input  logic              clr_we,
  input  logic [2:0]        clr_bits,
  output logic [15:0]       stat,
  output logic              irq,
  input  logic              pop,
  output logic [7:0]        pop_data,
  output logic              pop_vld
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [SYNC_N-1:0] sync_q;
  logic              line;
  logic              tick;
  logic              filt;
  logic              enc_push;
  run_byte_t         enc_byte;
  logic              enc_end;
  logic [CW-1:0]     fifo_cnt;
  logic              fifo_full;
  logic [6:0]        fill7;
  logic [FLG_N-1:0]  flg_q, set_vec, clr_vec;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_N-2:0], ir_in};
  end

  assign line = sync_q[SYNC_N-1] ^ inv;

  ir_tick_div #(.DIV(SAMPLE_DIV)) i_div (
    .clk(clk), .rst(rst), .en(en), .tick(tick)
  );

  ir_glitch_filt i_filt (
    .clk(clk), .rst(rst), .en(en), .tick(tick),
    .din(line), .thr(glitch_thr), .filt(filt)
  );

  ir_run_enc #(.IDLE_W(IDLE_W)) i_enc (
    .clk(clk), .rst(rst), .en(en), .tick(tick), .lvl_in(filt),
    .idle_thr(idle_thr), .push(enc_push), .dout(enc_byte),
    .pkt_end(enc_end)
  );

  ir_byte_fifo #(.DEPTH(DEPTH), .W(8)) i_fifo (
    .clk(clk), .rst(rst), .push(enc_push), .din(enc_byte),
    .pop(pop), .dout(pop_data), .dvld(pop_vld),
    .count(fifo_cnt), .full(fifo_full)
  );

  assign fill7 = 7'(fifo_cnt);

  always_comb begin
    set_vec          = '0;
    set_vec[FLG_LVL] = (lvl_trig != '0) && (fill7 >= lvl_trig);
    set_vec[FLG_END] = enc_end;
    set_vec[FLG_OVF] = enc_push && fifo_full;
    clr_vec          = clr_we ? clr_bits : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) flg_q <= '0;
    else     flg_q <= (flg_q & ~clr_vec) | set_vec;
  end

  assign stat = {1'b0, fill7, 5'b0, flg_q};
  assign irq  = |flg_q;

  // R8
  ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flg_q[FLG_OVF]) |-> $past(fifo_full));
  // R10
  end_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_we && clr_bits[FLG_END] && !enc_end) |=> !flg_q[FLG_END]);
endmodule

// File: tb/test_ir_rle_rx.sv
`timescale 1ns/1ps
module test_ir_rle_rx;
  localparam int DIV = 4;
  localparam int unsigned TBL [0:3][0:2] = '{
    '{5, 3, 7}, '{127, 15, 1}, '{1, 19, 2}, '{40, 10, 60}
  };

  logic clk = 1'b0;
  logic rst, en, inv, ir_in, clr_we, pop;
  logic [6:0] glitch_thr, lvl_trig;
  logic [11:0] idle_thr;
  logic [2:0] clr_bits;
  logic [15:0] stat;
  logic irq, pop_vld;
  logic [7:0] pop_data;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  ir_rle_rx i_ir_rle_rx (
    .clk(clk), .rst(rst), .en(en), .inv(inv), .glitch_thr(glitch_thr),
    .idle_thr(idle_thr), .lvl_trig(lvl_trig), .ir_in(ir_in),
    .clr_we(clr_we), .clr_bits(clr_bits), .stat(stat), .irq(irq),
    .pop(pop), .pop_data(pop_data), .pop_vld(pop_vld)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int n);
    ir_in = v;
    repeat (n * DIV) @(negedge clk);
  endtask

  task automatic pop_one(output logic [7:0] d, output logic v);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    d = pop_data;
    v = pop_vld;
  endtask

  task automatic clear(input logic [2:0] bits);
    clr_we = 1'b1;
    clr_bits = bits;
    @(negedge clk);
    clr_we = 1'b0;
    clr_bits = '0;
    @(negedge clk);
  endtask

  task automatic pop_expect(input string tag, input logic [7:0] exp);
    logic [7:0] d;
    logic v;
    pop_one(d, v);
    check({tag, " vld"}, int'(v), 1);
    check(tag, int'(d), int'(exp));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    logic v;
    rst = 1'b1; en = 1'b0; inv = 1'b0; ir_in = 1'b0; pop = 1'b0;
    clr_we = 1'b0; clr_bits = '0;
    glitch_thr = 7'd1; idle_thr = 12'd20; lvl_trig = 7'd4;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7 R10: reset state
    check("R7 reset stat", int'(stat), 0);
    check("R10 reset irq", int'(irq), 0);
    check("R7 reset vld", int'(pop_vld), 0);

    en = 1'b1;
    drive(1'b0, 10);

    // R1 R3 R9: vector table walked by one loop
    for (int k = 0; k < 4; k++) begin
      drive(1'b1, TBL[k][0]);
      drive(1'b0, TBL[k][1]);
      drive(1'b1, TBL[k][2]);
      drive(1'b0, 40);
      check("R3 count", int'(stat[14:8]), 3);
      check("R3 pkt_end", int'(stat[1]), 1);
      check("R9 below trig", int'(stat[0]), 0);
      pop_expect("R1 byte0", 8'h80 | 8'(TBL[k][0]));
      pop_expect("R1 byte1", 8'(TBL[k][1]));
      pop_expect("R1 byte2", 8'h80 | 8'(TBL[k][2]));
      clear(3'b111);
      check("R10 cleared", int'(stat[2:0]), 0);
    end

    // R2: 300 tick high run splits into 127,127,46
    drive(1'b1, 300);
    drive(1'b0, 40);
    check("R2 count", int'(stat[14:8]), 3);
    pop_expect("R2 first", 8'hFF);
    pop_expect("R2 second", 8'hFF);
    pop_expect("R2 rest", 8'hAE);
    clear(3'b111);

    // R4: a 2 tick dip under a threshold of 3 merges
    glitch_thr = 7'd3;
    drive(1'b1, 10);
    drive(1'b0, 2);
    drive(1'b1, 10);
    drive(1'b0, 40);
    check("R4 count", int'(stat[14:8]), 1);
    pop_expect("R4 merged", 8'h96);
    clear(3'b111);
    glitch_thr = 7'd1;

    // R5: inverted line
    en = 1'b0; inv = 1'b1; ir_in = 1'b1;
    repeat (4) @(negedge clk);
    en = 1'b1;
    drive(1'b1, 10);
    drive(1'b0, 8);
    drive(1'b1, 6);
    drive(1'b0, 4);
    drive(1'b1, 40);
    check("R5 count", int'(stat[14:8]), 3);
    pop_expect("R5 byte0", 8'h88);
    pop_expect("R5 byte1", 8'h06);
    pop_expect("R5 byte2", 8'h84);
    clear(3'b111);
    en = 1'b0; inv = 1'b0; ir_in = 1'b0;
    repeat (4) @(negedge clk);

    // R6: disabled capture ignores the line
    drive(1'b1, 10);
    drive(1'b0, 5);
    drive(1'b1, 10);
    drive(1'b0, 40);
    check("R6 stat", int'(stat), 0);
    en = 1'b1;
    drive(1'b0, 10);

    // R8 R9: 69 bytes into a 64 deep FIFO
    for (int p = 0; p < 35; p++) begin
      drive(1'b1, 3);
      drive(1'b0, 3);
    end
    drive(1'b0, 40);
    check("R8 count", int'(stat[14:8]), 64);
    check("R8 ovf flag", int'(stat[2]), 1);
    check("R9 lvl flag", int'(stat[0]), 1);
    check("R10 irq", int'(irq), 1);
    clear(3'b010);
    check("R10 selective", int'(stat[2:0]), 3'b101);
    for (int i = 0; i < 64; i++)
      pop_expect("R7 order", (i % 2 == 0) ? 8'h83 : 8'h03);
    pop_one(d, v);
    check("R7 empty pop", int'(v), 0);
    check("R7 drained", int'(stat[14:8]), 0);
    clear(3'b101);
    check("R10 all clear", int'(stat[2:0]), 0);
    check("R10 irq low", int'(irq), 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule